// File: doc/BRIEF.md
# Buffered Output-Compare PWM Timer

This block is a timer that makes PWM and timed output edges. A free-running up-counter wraps at a programmable limit, and that limit sets the period. Two compare channels watch the counter. Each channel drives its own pin. When tov mode is on, a channel's pin goes high when the counter wraps and goes low when the counter equals the compare value. The compare value therefore sets the pulse width. When tov mode is off, the pin simply flips on every compare match.

Software can link the two channels into one buffered channel. In that mode the pair drives the channel-0 pin, and the two compare registers take turns as the compare source. A new width goes into the register that is not in use. The block switches to it only at the next counter wrap, so a period is never cut short by a half-applied change. Software uses a byte-wide write port: each 16-bit value is staged by its high byte and committed by its low byte.

The link logic is a five-state machine:
- `ST_SOLO`: channels independent.
- `ST_HOLD0`: channel 0 is the source, nothing pending.
- `ST_HOLD0_NEXT1`: channel 0 is the source, channel 1 was written last.
- `ST_HOLD1`: channel 1 is the source, nothing pending.
- `ST_HOLD1_NEXT0`: channel 1 is the source, channel 0 was written last.

Its transitions:
- Setting link moves `ST_SOLO` to `ST_HOLD0`. Clearing link returns any state to `ST_SOLO`.
- A commit to the idle register moves `HOLDx` to `HOLDx_NEXTy`.
- In `HOLDx_NEXTy`, a counter wrap moves to `HOLDy`.
- In `HOLDx_NEXTy`, a commit to the active register cancels the pending switch and returns to `HOLDx`. This check is made before the wrap check.

Top module: `bcpwm_top`

## Requirements
- R1: The counter runs 0,1,…,M and then returns to 0, so the period is M+1 cycles. M is the modulo value, and a counter value at or above M counts as a wrap. Register map on `wr_addr`, all values reset to all ones:
  - 0 = modulo low byte, 1 = modulo high byte
  - 2 = channel-0 compare low byte, 3 = channel-0 compare high byte
  - 4 = channel-1 compare low byte, 5 = channel-1 compare high byte
  - 6 = control 0: bit0 link, bit1 tov, bit2 compare interrupt enable, bit3 overflow interrupt enable
  - 7 = control 1: bit1 tov, bit2 compare interrupt enable
- R2: With tov set, the pin goes high at the wrap and low at the cycle after the count equals the compare value C. In each period it is high for C+1 cycles out of M+1. If C > M, the pin stays high.
- R3: With tov clear, the pin flips once at each compare match, and the wrap has no effect on it.
- R4: If the compare value equals M, the wrap and the match fall on the same cycle. The wrap wins, and the pin is high for 100% of the period.
- R5: Writing a high byte only stages it. The 16-bit value changes only when its low byte is written, and it then takes the staged high byte.
- R6: When link is set, channel 0's value drives the channel-0 pin. A commit to channel 1 takes over at the next wrap, not earlier.
- R7: At each later wrap, the source becomes the channel committed last. A repeat write to the idle register replaces the pending value. A commit to the active register cancels the pending switch.
- R8: A commit to the register that drives a pin (unlinked, or active while linked) applies at once. If the counter has already passed the new value in that period, no match occurs until the next period.
- R9: While linked, `ch1_pin_free` is 1, `cmp_pin1` is held 0, and control 1 has no effect: no `cmp_irq1` and no channel-1 pin activity.
- R10: `ovf_irq` is a one-cycle pulse in the cycle after each wrap while overflow interrupts are enabled. `cmp_irqN` is a one-cycle pulse in the cycle after each match of channel N while its compare interrupt is enabled. Neither pulses while disabled.
- R11: After reset, the count is 0, both pins are 0, all interrupts are 0, and `ch1_pin_free` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write byte |
| count_o | output | CW | Current counter value |
| cmp_pin0 | output | 1 | Channel-0 (or buffered) compare pin |
| cmp_pin1 | output | 1 | Channel-1 compare pin |
| ch1_pin_free | output | 1 | Channel-1 pin released for general use |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| cmp_irq0 | output | 1 | Channel-0 / buffered compare interrupt pulse |
| cmp_irq1 | output | 1 | Channel-1 compare interrupt pulse |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is the counter wrap and the compare match, when the compare value equals the modulo value. The bench provokes this by setting the two equal, then counts the high cycles over one whole period. The wrap must win, so the pin must be high for all M+1 cycles.

The second pair is the wrap and the buffered source switch. The bench commits to the idle register early in a period and samples the pin just before the wrap. At that point the pin must still follow the old width. The bench then measures the following period, which must follow the new width. A second case places a write to the active register between a pending write and the wrap, and checks that the pending switch was dropped.

// File: rtl/bcpwm_pkg.sv
package bcpwm_pkg;

    typedef enum logic [2:0] {
        ST_SOLO,
        ST_HOLD0,
        ST_HOLD0_NEXT1,
        ST_HOLD1,
        ST_HOLD1_NEXT0
    } link_st_t;

    localparam logic [2:0] ADDR_CTL0 = 3'd6;
    localparam logic [2:0] ADDR_CTL1 = 3'd7;
    localparam int NUM_VALS = 3;   // modulo, compare 0, compare 1
    localparam int NUM_CH   = 2;

    typedef struct packed {
        logic oie;
        logic cie;
        logic tov;
        logic link;
    } ctl0_t;

    typedef struct packed {
        logic cie;
        logic tov;
    } ctl1_t;

endpackage

// File: rtl/bcpwm_regs.sv
module bcpwm_regs
    import bcpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [7:0]    wr_data,
    output logic [CW-1:0] mod_val,
    output logic [CW-1:0] cmp0_val,
    output logic [CW-1:0] cmp1_val,
    output logic          cmp0_commit,
    output logic          cmp1_commit,
    output ctl0_t         ctl0,
    output ctl1_t         ctl1
);
    localparam int HW = CW - 8;

    logic [CW-1:0] val   [NUM_VALS];
    logic [HW-1:0] stage [NUM_VALS];
    logic [NUM_VALS-1:0] commit;

    for (genvar g = 0; g < NUM_VALS; g++) begin : g_val
        localparam logic [2:0] LO_ADDR = 3'(2 * g);
        localparam logic [2:0] HI_ADDR = 3'(2 * g + 1);

        assign commit[g] = wr_en && (wr_addr == LO_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[g] <= '1;
                val[g]   <= '1;
            end else begin
                if (wr_en && (wr_addr == HI_ADDR))
                    stage[g] <= wr_data[HW-1:0];
                if (commit[g])
                    val[g] <= {stage[g], wr_data};
            end
        end

        // R5: a value only changes on its own low-byte write
        a_r5_low_commit: assert property (@(posedge clk) disable iff (!rst_n)
            !commit[g] |=> $stable(val[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl0 <= '0;
            ctl1 <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTL0)
                ctl0 <= wr_data[3:0];
            if (wr_addr == ADDR_CTL1)
                ctl1 <= wr_data[2:1];
        end
    end

    assign mod_val     = val[0];
    assign cmp0_val    = val[1];
    assign cmp1_val    = val[2];
    assign cmp0_commit = commit[1];
    assign cmp1_commit = commit[2];
endmodule

// File: rtl/bcpwm_cnt.sv
module bcpwm_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] mod_val,
    input  logic          ovf_ie,
    output logic [CW-1:0] cnt,
    output logic          ovf,
    output logic          ovf_irq
);
    assign ovf = (cnt >= mod_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            ovf_irq <= 1'b0;
        end else begin
            cnt     <= ovf ? '0 : cnt + 1'b1;
            ovf_irq <= ovf && ovf_ie;
        end
    end

    // R1: counting steps by one between wraps
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> cnt == $past(cnt) + 1'b1);
    // R1: the cycle after a wrap the count is zero
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> cnt == '0);
    // R10: overflow interrupt only follows an enabled wrap
    a_r10_ovf_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> $past(ovf_ie));
endmodule

// File: rtl/bcpwm_link.sv
module bcpwm_link
    import bcpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_req,
    input  logic ovf,
    input  logic wr0,
    input  logic wr1,
    output logic linked,
    output logic use1
);
    link_st_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_SOLO;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_SOLO: begin
                if (link_req) nxt = ST_HOLD0;
            end
            ST_HOLD0: begin
                if (!link_req) nxt = ST_SOLO;
                else if (wr1)  nxt = ST_HOLD0_NEXT1;
            end
            ST_HOLD0_NEXT1: begin
                if (!link_req) nxt = ST_SOLO;
                else if (wr0)  nxt = ST_HOLD0;
                else if (ovf)  nxt = ST_HOLD1;
            end
            ST_HOLD1: begin
                if (!link_req) nxt = ST_SOLO;
                else if (wr0)  nxt = ST_HOLD1_NEXT0;
            end
            ST_HOLD1_NEXT0: begin
                if (!link_req) nxt = ST_SOLO;
                else if (wr1)  nxt = ST_HOLD1;
                else if (ovf)  nxt = ST_HOLD0;
            end
            default: nxt = ST_SOLO;
        endcase
    end

    always_comb begin
        linked = 1'b1;
        use1   = 1'b0;
        unique case (st)
            ST_SOLO:        linked = 1'b0;
            ST_HOLD0:       use1   = 1'b0;
            ST_HOLD0_NEXT1: use1   = 1'b0;
            ST_HOLD1:       use1   = 1'b1;
            ST_HOLD1_NEXT0: use1   = 1'b1;
            default:        linked = 1'b0;
        endcase
    end

    // R6: entering link mode always starts on channel 0
    a_r6_start0: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SOLO && link_req) |=> (linked && !use1));
    // R6: the source only changes at a wrap while linked
    a_r6_switch_at_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && link_req && !ovf) |=> $stable(use1));
    // R7: pending channel 1 takes over at the wrap
    a_r7_take1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD0_NEXT1 && link_req && ovf && !wr0) |=> st == ST_HOLD1);
    // R7: an active write drops the pending switch
    a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD1_NEXT0 && link_req && wr1) |=> st == ST_HOLD1);
endmodule

// File: rtl/bcpwm_pin.sv
module bcpwm_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tov,
    input  logic cie,
    input  logic ovf,
    input  logic match,
    output logic pin,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
            irq <= 1'b0;
        end else begin
            irq <= en && cie && match;
            if (!en)
                pin <= 1'b0;
            else if (tov) begin
                if (ovf)        pin <= 1'b1;
                else if (match) pin <= 1'b0;
            end else if (match)
                pin <= ~pin;
        end
    end

    // R4: a wrap with tov always leaves the pin high
    a_r4_ovf_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tov && ovf) |=> pin);
    // R3: without tov, a cycle with no match holds the pin
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tov && !match) |=> $stable(pin));
    // R10: a compare interrupt needs an enabled match
    a_r10_cmp_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cie && match && en));
endmodule

// File: rtl/bcpwm_top.sv
module bcpwm_top
    import bcpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [7:0]    wr_data,
    output logic [CW-1:0] count_o,
    output logic          cmp_pin0,
    output logic          cmp_pin1,
    output logic          ch1_pin_free,
    output logic          ovf_irq,
    output logic          cmp_irq0,
    output logic          cmp_irq1
);
    logic [CW-1:0] mod_val, cmp0_val, cmp1_val, cmp_src0;
    logic          cmp0_commit, cmp1_commit;
    ctl0_t         ctl0;
    ctl1_t         ctl1;
    logic          ovf, linked, use1;

    logic [NUM_CH-1:0] ch_en, ch_tov, ch_cie, ch_match, ch_pin, ch_irq;

    bcpwm_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mod_val(mod_val), .cmp0_val(cmp0_val),
        .cmp1_val(cmp1_val), .cmp0_commit(cmp0_commit),
        .cmp1_commit(cmp1_commit), .ctl0(ctl0), .ctl1(ctl1)
    );

    bcpwm_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mod_val(mod_val), .ovf_ie(ctl0.oie),
        .cnt(count_o), .ovf(ovf), .ovf_irq(ovf_irq)
    );

    bcpwm_link u_link (
        .clk(clk), .rst_n(rst_n), .link_req(ctl0.link), .ovf(ovf),
        .wr0(cmp0_commit), .wr1(cmp1_commit), .linked(linked), .use1(use1)
    );

    // Buffered source selection for the channel-0 pin
    assign cmp_src0 = (linked && use1) ? cmp1_val : cmp0_val;

    assign ch_match[0] = (count_o == cmp_src0);
    assign ch_match[1] = (count_o == cmp1_val);
    assign ch_en[0]    = 1'b1;
    assign ch_en[1]    = !linked;
    assign ch_tov[0]   = ctl0.tov;
    assign ch_tov[1]   = ctl1.tov;
    assign ch_cie[0]   = ctl0.cie;
    assign ch_cie[1]   = ctl1.cie;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bcpwm_pin u_pin (
            .clk(clk), .rst_n(rst_n), .en(ch_en[c]), .tov(ch_tov[c]),
            .cie(ch_cie[c]), .ovf(ovf), .match(ch_match[c]),
            .pin(ch_pin[c]), .irq(ch_irq[c])
        );
    end

    assign cmp_pin0     = ch_pin[0];
    assign cmp_pin1     = ch_pin[1];
    assign cmp_irq0     = ch_irq[0];
    assign cmp_irq1     = ch_irq[1];
    assign ch1_pin_free = linked;

    // R9: a released channel-1 pin stays low and silent
    a_r9_pin1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_pin_free && $past(ch1_pin_free)) |-> (!cmp_pin1 && !cmp_irq1));
    // R11: outputs come out of reset quiet
    a_r11_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!cmp_pin0 && !cmp_pin1 && !ovf_irq));
endmodule

// File: tb/sim_bcpwm_top.sv
module sim_bcpwm_top;
    localparam int CW = 16;
    localparam int MOD = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [CW-1:0] count_o;
    logic cmp_pin0, cmp_pin1, ch1_pin_free, ovf_irq, cmp_irq0, cmp_irq1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    bcpwm_top #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .cmp_pin0(cmp_pin0),
        .cmp_pin1(cmp_pin1), .ch1_pin_free(ch1_pin_free), .ovf_irq(ovf_irq),
        .cmp_irq0(cmp_irq0), .cmp_irq1(cmp_irq1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr8(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] lo_addr, input logic [15:0] v);
        wr8(lo_addr + 3'd1, v[15:8]);
        wr8(lo_addr, v[7:0]);
    endtask

    task automatic wait_cnt(input int v);
        while (count_o != CW'(v)) @(negedge clk);
    endtask

    // High cycles of pin0 over one period starting at count 0
    task automatic duty0(output int hi);
        hi = 0;
        wait_cnt(0);
        for (int i = 0; i <= MOD; i++) begin
            if (cmp_pin0) hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check(count_o == 0, "R11 count", int'(count_o), 0);
        check(!cmp_pin0 && !cmp_pin1, "R11 pins", int'({cmp_pin1, cmp_pin0}), 0);
        check(!ovf_irq && !cmp_irq0 && !cmp_irq1, "R11 irqs",
              int'({ovf_irq, cmp_irq0, cmp_irq1}), 0);
        check(!ch1_pin_free, "R11 free", int'(ch1_pin_free), 0);
    endtask

    task automatic t_period;
        int hi, rises;
        logic prev;
        wr16(3'd0, 16'(MOD));
        wr16(3'd2, 16'd3);
        wr8(3'd6, 8'b0000_0010);
        wait_cnt(5);
        wait_cnt(0);
        duty0(hi);
        check(hi == 4, "R2 duty C=3", hi, 4);
        rises = 0; prev = cmp_pin0;
        for (int i = 0; i < 3 * (MOD + 1); i++) begin
            @(negedge clk);
            if (cmp_pin0 && !prev) rises++;
            prev = cmp_pin0;
        end
        check(rises == 3, "R1 period", rises, 3);
        wr16(3'd2, 16'd12);
        duty0(hi); duty0(hi);
        check(hi == MOD + 1, "R2 C>M high", hi, MOD + 1);
    endtask

    task automatic t_equal;
        int hi;
        wr16(3'd2, 16'(MOD));
        duty0(hi); duty0(hi);
        check(hi == MOD + 1, "R4 C==M full duty", hi, MOD + 1);
    endtask

    task automatic t_no_tov;
        int flips;
        logic prev;
        wr16(3'd2, 16'd3);
        wr8(3'd6, 8'b0000_0000);
        wait_cnt(0);
        flips = 0; prev = cmp_pin0;
        for (int i = 0; i < 2 * (MOD + 1); i++) begin
            @(negedge clk);
            if (cmp_pin0 != prev) flips++;
            prev = cmp_pin0;
        end
        check(flips == 2, "R3 toggles per period", flips, 2);
    endtask

    task automatic t_low_latch;
        int hi;
        wr8(3'd6, 8'b0000_0010);
        wr16(3'd2, 16'd3);
        duty0(hi);
        wr8(3'd3, 8'h01);            // high byte only
        duty0(hi); duty0(hi);
        check(hi == 4, "R5 staged high byte unused", hi, 4);
        wr8(3'd2, 8'h05);            // commit -> 0x0105 > M
        duty0(hi); duty0(hi);
        check(hi == MOD + 1, "R5 low byte commits", hi, MOD + 1);
        wr16(3'd2, 16'd3);
    endtask

    task automatic t_irq;
        int no, nc;
        wr8(3'd6, 8'b0000_1110);
        wait_cnt(0);
        no = 0; nc = 0;
        for (int i = 0; i < 2 * (MOD + 1); i++) begin
            @(negedge clk);
            if (ovf_irq) no++;
            if (cmp_irq0) nc++;
        end
        check(no == 2, "R10 ovf pulses", no, 2);
        check(nc == 2, "R10 cmp pulses", nc, 2);
        wr8(3'd6, 8'b0000_0010);
        wait_cnt(0);
        no = 0; nc = 0;
        for (int i = 0; i < 2 * (MOD + 1); i++) begin
            @(negedge clk);
            if (ovf_irq) no++;
            if (cmp_irq0) nc++;
        end
        check(no == 0 && nc == 0, "R10 disabled", no + nc, 0);
    endtask

    task automatic t_unbuf_immediate;
        int hi;
        wr16(3'd2, 16'd8);
        duty0(hi);
        wait_cnt(5);
        wr16(3'd2, 16'd2);           // commits at count 6: already passed
        wait_cnt(9);
        check(cmp_pin0 == 1'b1, "R8 passed value misses", int'(cmp_pin0), 1);
        duty0(hi);
        check(hi == 3, "R8 new value next period", hi, 3);
    endtask

    task automatic t_linked;
        int hi, n1;
        wr16(3'd2, 16'd8);
        wr16(3'd4, 16'd5);
        wr8(3'd6, 8'b0000_0011);     // link + tov
        duty0(hi);
        check(hi == 9, "R6 channel 0 first", hi, 9);
        check(ch1_pin_free == 1'b1, "R9 pin freed", int'(ch1_pin_free), 1);
        // write idle channel 1 early; must not act before the wrap
        wait_cnt(1);
        wr16(3'd4, 16'd2);
        wait_cnt(9);
        check(cmp_pin0 == 1'b0, "R6 no early switch", int'(cmp_pin0), 0);
        duty0(hi);
        check(hi == 3, "R6 switch at wrap", hi, 3);
        // pending ch0, then active ch1 write cancels it
        wait_cnt(1);
        wr16(3'd2, 16'd4);
        wr16(3'd4, 16'd6);
        duty0(hi); duty0(hi);
        check(hi == 7, "R7 active write cancels", hi, 7);
        wait_cnt(1);
        wr16(3'd2, 16'd4);
        duty0(hi);
        check(hi == 5, "R7 last written ch0", hi, 5);
        // repeated idle writes: last one wins
        wait_cnt(1);
        wr16(3'd4, 16'd3);
        wr16(3'd4, 16'd5);
        duty0(hi);
        check(hi == 6, "R7 pending replaced", hi, 6);
        // active channel 1 write applies at once
        wait_cnt(1);
        wr16(3'd4, 16'd8);
        wait_cnt(7);
        check(cmp_pin0 == 1'b1, "R8 active write immediate", int'(cmp_pin0), 1);
        wait_cnt(9);
        check(cmp_pin0 == 1'b0, "R8 new match used", int'(cmp_pin0), 0);
        wait_cnt(5);
        wr16(3'd4, 16'd2);
        wait_cnt(9);
        check(cmp_pin0 == 1'b1, "R8 linked passed value", int'(cmp_pin0), 1);
        // channel 1 control is ignored while linked
        wr8(3'd7, 8'b0000_0110);
        wait_cnt(0);
        n1 = 0;
        for (int i = 0; i < 2 * (MOD + 1); i++) begin
            @(negedge clk);
            if (cmp_irq1 || cmp_pin1) n1++;
        end
        check(n1 == 0, "R9 channel 1 silent", n1, 0);
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        check(1'b0, "watchdog", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_period();
        t_equal();
        t_no_tov();
        t_low_latch();
        t_irq();
        t_unbuf_immediate();
        t_linked();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule